// File: doc/BRIEF.md
# Address Region Cacheability Decoder

This block classifies every physical address a processor core issues. Software programs a small bank of byte-wide configuration registers through an index/data port. Those registers describe four programmable address regions and two fixed legacy holes. A purely combinational lookup path then takes a 32-bit address and a real/virtual-8086 mode flag. From them it reports three things: whether the access may be cached, whether it is write-protected, and whether it lands in system-management memory.

Each programmable region is given as a start address with 4 KB granularity and a 4-bit size code. The hardware aligns the start down to a multiple of the region size without reporting it. Region 1, region 2 and region 3 each have a type bit that makes the region either non-cacheable or cacheable-but-write-protected. Region 4 can be dedicated to system-management memory, which is never cached. The first fixed hole covers 640 KB up to 1 MB. The second covers the low 64 KB of every megabyte, and it applies only while the mode flag is high.

Top module: `region_cache_decoder`

## Requirements
- R1: After reset every register reads zero. Every region is disabled and both holes are off, so all addresses report cacheable, not write-protected and not system-management space.
- R2: Registers are reached through an 8-bit index:
  - C0h is config 0 and C1h is config 1.
  - C4h–CFh hold regions 1 to 4, three bytes per region in ascending order.
  - A write to any other index changes nothing, and a read of any other index returns 00h.
- R3: In a region's third byte, the lower nibble is the size code:
  - Code 0 disables the region.
  - Code n from 1 to Eh spans 2^(11+n) bytes, so 1 is 4 KB and Eh is 32 MB.
  - Code Fh spans the whole 4 GB space.
- R4: The start address has three fields: the first byte gives address bits 31–24, the second byte gives bits 23–16, and the upper nibble of the third byte gives bits 15–12. Every start bit below the region size is treated as zero. An address hits when it lies in the aligned block of that size.
- R5: A hit on region 1, 2 or 3 whose type bit is 0 makes the address non-cacheable. The type bits are config 1 bits 4, 5 and 6.
- R6: A hit on region 1, 2 or 3 whose type bit is 1 leaves the address cacheable and asserts write-protect.
- R7: When config 1 bit 7 is set, a hit on region 4 makes the address non-cacheable and asserts the system-management output. When that bit is clear, region 4 has no effect, and the system-management output is low for every address.
- R8: When config 0 bit 1 is set, addresses from 000A0000h to 000FFFFFh are non-cacheable.
- R9: When config 0 bit 0 is set and the mode flag is high, address bits 19–16 all zero make the address non-cacheable. With the mode flag low, this hole has no effect.
- R10: Non-cacheable wins over write-protect. Write-protect is asserted only for a cacheable address.
- R11: A register write takes effect on the clock edge that accepts it. Lookups and reads in the same cycle still see the old value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_idx_i | input | 8 | Register index for write and read |
| cfg_wdata_i | input | 8 | Write data |
| cfg_rdata_o | output | 8 | Read data for cfg_idx_i, combinational |
| addr_i | input | 32 | Physical address to classify |
| v86_mode_i | input | 1 | Real/virtual-8086 mode flag |
| cacheable_o | output | 1 | Address may be cached |
| wprot_o | output | 1 | Address is cacheable and write-protected |
| smm_space_o | output | 1 | Address is in system-management memory |

## Verification
The bench builds the block with its default parameters: an 8-bit index, config registers at C0h/C1h and the region bank at C4h. With those values the whole index space can be swept, including the unused C2h/C3h gap and indices above CFh.

Directed phases cover the following:
- misaligned starts;
- overlapping regions with conflicting types;
- the 4 GB and disabled size codes;
- both legacy holes with the mode flag toggled.

A long random phase mixes writes and lookups, biased into the low 2 MB where the holes and regions interact. Each cycle it compares all outputs with an arithmetic reference model.

// File: rtl/region_dec_pkg.sv
package region_dec_pkg;
  localparam int ADDR_W        = 32;
  localparam int PAGE_W        = 12;
  localparam int START_W       = ADDR_W - PAGE_W;
  localparam int N_RGN         = 4;
  localparam int BYTES_PER_RGN = 3;
  localparam int N_RGN_BYTES   = N_RGN * BYTES_PER_RGN;

  localparam logic [3:0] SZ_OFF = 4'h0;
  localparam logic [3:0] SZ_ALL = 4'hF;

  // config 0 / config 1 bit positions
  localparam int C0_V86_HOLE = 0;
  localparam int C0_LEG_HOLE = 1;
  localparam int C1_TYPE_LSB = 4;
  localparam int C1_SMM_EN   = 7;

  localparam logic [ADDR_W-1:0] LEG_LO = 32'h000A_0000;
  localparam logic [ADDR_W-1:0] LEG_HI = 32'h0010_0000;

  typedef struct packed {
    logic [START_W-1:0] start;
    logic [3:0]         size;
  } region_t;
endpackage

// File: rtl/region_cfg_regs.sv
module region_cfg_regs
  import region_dec_pkg::*;
#(
  parameter int               IDX_W    = 8,
  parameter logic [IDX_W-1:0] CFG0_IDX = 8'hC0,
  parameter logic [IDX_W-1:0] CFG1_IDX = 8'hC1,
  parameter logic [IDX_W-1:0] RGN_IDX  = 8'hC4
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    we_i,
  input  logic [IDX_W-1:0]        idx_i,
  input  logic [7:0]              wdata_i,
  output logic [7:0]              rdata_o,
  output logic [7:0]              cfg0_o,
  output logic [7:0]              cfg1_o,
  output region_t [N_RGN-1:0]     rgn_o
);
  localparam int OFF_W = $clog2(N_RGN_BYTES);

  logic [7:0]       cfg0_q, cfg1_q;
  logic [7:0]       rgn_q [N_RGN_BYTES];
  logic [IDX_W-1:0] rgn_off;
  logic [OFF_W-1:0] rgn_ptr;
  logic             rgn_sel;

  assign rgn_off = idx_i - RGN_IDX;
  assign rgn_ptr = rgn_off[OFF_W-1:0];
  assign rgn_sel = (idx_i >= RGN_IDX) && (rgn_off < IDX_W'(N_RGN_BYTES));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg0_q <= '0;
      cfg1_q <= '0;
      for (int i = 0; i < N_RGN_BYTES; i++) rgn_q[i] <= '0;
    end else if (we_i) begin
      if (idx_i == CFG0_IDX)      cfg0_q <= wdata_i;
      else if (idx_i == CFG1_IDX) cfg1_q <= wdata_i;
      else if (rgn_sel)           rgn_q[rgn_ptr] <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (idx_i == CFG0_IDX)      rdata_o = cfg0_q;
    else if (idx_i == CFG1_IDX) rdata_o = cfg1_q;
    else if (rgn_sel)           rdata_o = rgn_q[rgn_ptr];
  end

  assign cfg0_o = cfg0_q;
  assign cfg1_o = cfg1_q;

  for (genvar g = 0; g < N_RGN; g++) begin : g_rgn
    assign rgn_o[g].start = {rgn_q[BYTES_PER_RGN*g],
                             rgn_q[BYTES_PER_RGN*g+1],
                             rgn_q[BYTES_PER_RGN*g+2][7:4]};
    assign rgn_o[g].size  = rgn_q[BYTES_PER_RGN*g+2][3:0];
  end
endmodule

// File: rtl/region_hit.sv
module region_hit
  import region_dec_pkg::*;
(
  input  logic [ADDR_W-1:0] addr_i,
  input  region_t           rgn_i,
  output logic              hit_o
);
  // size code n keeps address bits [31 : 11+n]; lower bits are ignored (alignment)
  always_comb begin
    hit_o = 1'b0;
    if (rgn_i.size == SZ_ALL) begin
      hit_o = 1'b1;
    end else if (rgn_i.size != SZ_OFF) begin
      hit_o = 1'b1;
      for (int b = PAGE_W; b < ADDR_W; b++) begin
        if ((b >= PAGE_W - 1 + int'(rgn_i.size)) && (addr_i[b] != rgn_i.start[b-PAGE_W]))
          hit_o = 1'b0;
      end
    end
  end
endmodule

// File: rtl/region_attr.sv
module region_attr
  import region_dec_pkg::*;
(
  input  logic [N_RGN-1:0]  hit_i,
  input  logic [7:0]        cfg0_i,
  input  logic [7:0]        cfg1_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              v86_mode_i,
  output logic              cacheable_o,
  output logic              wprot_o,
  output logic              smm_space_o
);
  logic [N_RGN-2:0] rgn_nc, rgn_wp;
  logic             smm_hit, leg_hole, v86_hole, non_cache;

  for (genvar g = 0; g < N_RGN - 1; g++) begin : g_type
    assign rgn_wp[g] = hit_i[g] &  cfg1_i[C1_TYPE_LSB+g];
    assign rgn_nc[g] = hit_i[g] & ~cfg1_i[C1_TYPE_LSB+g];
  end

  assign smm_hit  = hit_i[N_RGN-1] & cfg1_i[C1_SMM_EN];
  assign leg_hole = cfg0_i[C0_LEG_HOLE] && (addr_i >= LEG_LO) && (addr_i < LEG_HI);
  assign v86_hole = cfg0_i[C0_V86_HOLE] && v86_mode_i && (addr_i[19:16] == 4'h0);

  assign non_cache   = (|rgn_nc) | smm_hit | leg_hole | v86_hole;
  assign cacheable_o = ~non_cache;
  assign wprot_o     = (|rgn_wp) & ~non_cache;
  assign smm_space_o = smm_hit;
endmodule

// File: rtl/region_cache_decoder.sv
module region_cache_decoder
  import region_dec_pkg::*;
#(
  parameter int               IDX_W    = 8,
  parameter logic [IDX_W-1:0] CFG0_IDX = 8'hC0,
  parameter logic [IDX_W-1:0] CFG1_IDX = 8'hC1,
  parameter logic [IDX_W-1:0] RGN_IDX  = 8'hC4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [IDX_W-1:0]  cfg_idx_i,
  input  logic [7:0]        cfg_wdata_i,
  output logic [7:0]        cfg_rdata_o,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              v86_mode_i,
  output logic              cacheable_o,
  output logic              wprot_o,
  output logic              smm_space_o
);
  logic [7:0]           cfg0, cfg1;
  region_t [N_RGN-1:0]  rgn;
  logic [N_RGN-1:0]     hit;

  region_cfg_regs #(
    .IDX_W(IDX_W), .CFG0_IDX(CFG0_IDX), .CFG1_IDX(CFG1_IDX), .RGN_IDX(RGN_IDX)
  ) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .idx_i   (cfg_idx_i),
    .wdata_i (cfg_wdata_i),
    .rdata_o (cfg_rdata_o),
    .cfg0_o  (cfg0),
    .cfg1_o  (cfg1),
    .rgn_o   (rgn)
  );

  for (genvar g = 0; g < N_RGN; g++) begin : g_hit
    region_hit u_hit (
      .addr_i (addr_i),
      .rgn_i  (rgn[g]),
      .hit_o  (hit[g])
    );
  end

  region_attr u_attr (
    .hit_i       (hit),
    .cfg0_i      (cfg0),
    .cfg1_i      (cfg1),
    .addr_i      (addr_i),
    .v86_mode_i  (v86_mode_i),
    .cacheable_o (cacheable_o),
    .wprot_o     (wprot_o),
    .smm_space_o (smm_space_o)
  );
endmodule

// File: rtl/region_cache_decoder_chk.sv
module region_cache_decoder_chk
  import region_dec_pkg::*;
#(
  parameter int               IDX_W    = 8,
  parameter logic [IDX_W-1:0] CFG0_IDX = 8'hC0,
  parameter logic [IDX_W-1:0] CFG1_IDX = 8'hC1,
  parameter logic [IDX_W-1:0] RGN_IDX  = 8'hC4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cfg_we_i,
  input logic [IDX_W-1:0]  cfg_idx_i,
  input logic [7:0]        cfg_wdata_i,
  input logic [7:0]        cfg_rdata_o,
  input logic [ADDR_W-1:0] addr_i,
  input logic              v86_mode_i,
  input logic              cacheable_o,
  input logic              wprot_o,
  input logic              smm_space_o,
  input logic [7:0]        cfg0_i,
  input logic [7:0]        cfg1_i
);
  logic mapped;
  assign mapped = (cfg_idx_i == CFG0_IDX) || (cfg_idx_i == CFG1_IDX) ||
                  ((int'(cfg_idx_i) >= int'(RGN_IDX)) &&
                   (int'(cfg_idx_i) <  int'(RGN_IDX) + N_RGN_BYTES));

  AST_WP_ONLY_IF_CACHEABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wprot_o |-> cacheable_o); // R10
  AST_SMM_NOT_CACHEABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smm_space_o |-> !cacheable_o); // R7
  AST_SMM_NEEDS_ENABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg1_i[C1_SMM_EN] |-> !smm_space_o); // R7
  AST_UNMAPPED_READ_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mapped |-> (cfg_rdata_o == 8'h00)); // R2
  AST_WRITE_LANDS_NEXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && mapped) |=> ((cfg_idx_i != $past(cfg_idx_i)) ||
                              (cfg_rdata_o == $past(cfg_wdata_i)))); // R11
  AST_LEGACY_HOLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg0_i[C0_LEG_HOLE] && addr_i >= LEG_LO && addr_i < LEG_HI) |-> !cacheable_o); // R8
  AST_V86_HOLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg0_i[C0_V86_HOLE] && v86_mode_i && addr_i[19:16] == 4'h0) |-> !cacheable_o); // R9
endmodule

bind region_cache_decoder region_cache_decoder_chk #(
  .IDX_W(IDX_W), .CFG0_IDX(CFG0_IDX), .CFG1_IDX(CFG1_IDX), .RGN_IDX(RGN_IDX)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cfg_we_i    (cfg_we_i),
  .cfg_idx_i   (cfg_idx_i),
  .cfg_wdata_i (cfg_wdata_i),
  .cfg_rdata_o (cfg_rdata_o),
  .addr_i      (addr_i),
  .v86_mode_i  (v86_mode_i),
  .cacheable_o (cacheable_o),
  .wprot_o     (wprot_o),
  .smm_space_o (smm_space_o),
  .cfg0_i      (cfg0),
  .cfg1_i      (cfg1)
);

// File: tb/region_cache_decoder_tb.sv
`timescale 1ns/1ps
module region_cache_decoder_tb;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_we_i = 1'b0;
  logic [7:0]  cfg_idx_i = 8'h00;
  logic [7:0]  cfg_wdata_i = 8'h00;
  logic [7:0]  cfg_rdata_o;
  logic [31:0] addr_i = 32'h0;
  logic        v86_mode_i = 1'b0;
  logic        cacheable_o, wprot_o, smm_space_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [7:0] mreg [256];

  always #4 clk = ~clk;

  region_cache_decoder u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .cfg_we_i(cfg_we_i), .cfg_idx_i(cfg_idx_i),
    .cfg_wdata_i(cfg_wdata_i), .cfg_rdata_o(cfg_rdata_o), .addr_i(addr_i),
    .v86_mode_i(v86_mode_i), .cacheable_o(cacheable_o), .wprot_o(wprot_o),
    .smm_space_o(smm_space_o)
  );

  function automatic bit is_mapped(int i);
    return (i == 'hC0) || (i == 'hC1) || (i >= 'hC4 && i <= 'hCF);
  endfunction

  // arithmetic reference: regions as [base, base+size) intervals
  function automatic void ref_eval(input logic [31:0] a, input bit v,
                                   output bit c, output bit w, output bit s);
    bit nc = 0, wp = 0;
    longint av = longint'({32'h0, a});
    s = 0;
    for (int r = 0; r < 4; r++) begin
      int     b0 = 'hC4 + 3 * r;
      int     code = int'(mreg[b0+2][3:0]);
      longint st = longint'({32'h0, mreg[b0], mreg[b0+1], mreg[b0+2][7:4], 12'h000});
      bit     hit = 0;
      if (code == 15) hit = 1;
      else if (code != 0) begin
        longint sz = longint'(1) << (11 + code);
        longint base = st - (st % sz);
        hit = (av >= base) && (av < base + sz);
      end
      if (r < 3 && hit) begin
        if (mreg['hC1][4+r]) wp = 1; else nc = 1;
      end
      if (r == 3 && hit && mreg['hC1][7]) begin nc = 1; s = 1; end
    end
    if (mreg['hC0][1] && av >= 'hA0000 && av < 'h100000) nc = 1;
    if (mreg['hC0][0] && v && (av % (1 << 20)) < (1 << 16)) nc = 1;
    c = !nc;
    w = wp && !nc;
  endfunction

  task automatic check_val(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s addr=%h idx=%h actual=%h expected=%h",
               req, what, addr_i, cfg_idx_i, act, exp);
    end
  endtask

  task automatic compare_all(string req);
    bit c, w, s;
    logic [7:0] rexp;
    ref_eval(addr_i, v86_mode_i, c, w, s);
    rexp = is_mapped(int'(cfg_idx_i)) ? mreg[cfg_idx_i] : 8'h00;
    check_val(req, "cacheable", {31'h0, cacheable_o}, {31'h0, c});
    check_val(req, "wprot", {31'h0, wprot_o}, {31'h0, w});
    check_val(req, "smm", {31'h0, smm_space_o}, {31'h0, s});
    check_val(req, "rdata", {24'h0, cfg_rdata_o}, {24'h0, rexp});
  endtask

  // R11: old value seen during the write cycle, new value after the edge
  task automatic wr(logic [7:0] idx, logic [7:0] data);
    cfg_we_i = 1'b1; cfg_idx_i = idx; cfg_wdata_i = data;
    #1 compare_all("R11");
    @(posedge clk);
    if (is_mapped(int'(idx))) mreg[idx] = data;
    @(negedge clk);
    cfg_we_i = 1'b0;
    #1 compare_all("R11");
  endtask

  task automatic probe(logic [31:0] a, bit v, string req);
    addr_i = a; v86_mode_i = v;
    #1 compare_all(req);
  endtask

  task automatic rd(logic [7:0] idx, string req);
    cfg_idx_i = idx;
    #1 compare_all(req);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mreg[i] = 8'h00;
    repeat (2) @(negedge clk);
    // R1: state during and after reset
    probe(32'h000A_0000, 1'b1, "R1");
    rst_ni = 1'b1;
    @(negedge clk);
    for (int i = 'hC0; i <= 'hCF; i++) rd(8'(i), "R1");
    probe(32'h0000_1000, 1'b1, "R1");
    check_val("R1", "cacheable_direct", {31'h0, cacheable_o}, 32'h1);

    // R2: unmapped indices
    wr(8'hC2, 8'hFF); wr(8'hD0, 8'hAA); wr(8'hBF, 8'h55); wr(8'hC3, 8'h11);
    rd(8'hC2, "R2"); rd(8'hD0, "R2"); rd(8'hC0, "R2"); rd(8'hC1, "R2");
    check_val("R2", "rd_C2_direct", {24'h0, cfg_rdata_o}, 32'h0);
    probe(32'h000A_0000, 1'b1, "R2");

    // R3/R5: region 1 at A0000, 128 KB, non-cacheable
    wr(8'hC5, 8'h0A); wr(8'hC6, 8'h06);
    probe(32'h0009_FFFF, 0, "R3"); probe(32'h000A_0000, 0, "R5");
    probe(32'h000B_FFFF, 0, "R5"); probe(32'h000C_0000, 0, "R3");
    check_val("R5", "cacheable_direct", {31'h0, cacheable_o}, 32'h1);

    // R4: region 2 programmed at D0000 with 256 KB aligns to C0000
    wr(8'hC8, 8'h0D); wr(8'hC9, 8'h07);
    probe(32'h000B_FFFF, 0, "R4"); probe(32'h000C_0000, 0, "R4");
    check_val("R4", "cacheable_direct", {31'h0, cacheable_o}, 32'h0);
    probe(32'h000F_FFFF, 0, "R4"); probe(32'h0010_0000, 0, "R4");

    // R6: region 2 becomes write-protected
    wr(8'hC1, 8'h20);
    probe(32'h000C_5000, 0, "R6");
    check_val("R6", "wprot_direct", {31'h0, wprot_o}, 32'h1);

    // R10: region 3 (4 KB at C0000, non-cacheable) overlaps region 2
    wr(8'hCB, 8'h0C); wr(8'hCC, 8'h01);
    probe(32'h000C_0800, 0, "R10");
    check_val("R10", "wprot_direct", {31'h0, wprot_o}, 32'h0);
    probe(32'h000C_1000, 0, "R10");
    wr(8'hC1, 8'h60);
    probe(32'h000C_0800, 0, "R10");

    // R7: region 4 at 12345000, 8 KB -> aligned 12344000
    wr(8'hCD, 8'h12); wr(8'hCE, 8'h34); wr(8'hCF, 8'h52);
    probe(32'h1234_4000, 0, "R7");
    wr(8'hC1, 8'hA0);
    probe(32'h1234_4000, 0, "R7");
    check_val("R7", "smm_direct", {31'h0, smm_space_o}, 32'h1);
    probe(32'h1234_5FFF, 0, "R7"); probe(32'h1234_6000, 0, "R7");
    probe(32'h1234_3FFF, 0, "R7");

    // R3: 4 GB code and disabled code
    wr(8'hCC, 8'h0F);
    probe(32'h8000_0000, 0, "R3"); probe(32'hFFFF_FFFF, 1, "R3");
    wr(8'hCC, 8'h00); wr(8'hC6, 8'h00); wr(8'hC9, 8'h00);
    probe(32'h000A_0000, 0, "R3"); probe(32'h000C_0000, 0, "R3");

    // R8: legacy hole
    wr(8'hC0, 8'h02);
    probe(32'h0009_FFFF, 0, "R8"); probe(32'h000A_0000, 0, "R8");
    probe(32'h000F_FFFF, 0, "R8"); probe(32'h0010_0000, 0, "R8");

    // R9: low 64 KB of each megabyte in mode
    wr(8'hC0, 8'h01);
    probe(32'h0030_5000, 0, "R9"); probe(32'h0030_5000, 1, "R9");
    check_val("R9", "cacheable_direct", {31'h0, cacheable_o}, 32'h0);
    probe(32'h0031_5000, 1, "R9"); probe(32'h0000_FFFF, 1, "R9");
    probe(32'hFFF0_0000, 1, "R9");

    // random mix: R2/R11 read and timing plus everything else via the model
    for (int n = 0; n < 3000; n++) begin
      @(negedge clk);
      cfg_we_i    = ($urandom % 10) < 3;
      cfg_idx_i   = (($urandom % 10) < 8) ? 8'(8'hC0 + $urandom % 16) : 8'($urandom);
      cfg_wdata_i = 8'($urandom);
      addr_i      = (($urandom % 2) == 0) ? ($urandom & 32'h001F_FFFF) : $urandom;
      v86_mode_i  = 1'($urandom);
      #1 compare_all("R2/R11");
      @(posedge clk);
      if (cfg_we_i && is_mapped(int'(cfg_idx_i))) mreg[cfg_idx_i] = cfg_wdata_i;
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule